// File: doc/BRIEF.md
# Endpoint Interrupt Enable and DMA Pause Gate

This block holds the interrupt enables of one endpoint. Software sets and clears each enable through separate strobes. A one on a set strobe sets the bit, and a one on a clear strobe clears it. The pending event flags of the endpoint are ANDed with these enables, and the results are ORed into a registered interrupt line.

A "pause DMA on event" control bit also lives here. While it is set, any pending event withholds the endpoint's DMA request, whether or not that event's interrupt is enabled. Bank tracking comes in as plain inputs: a per-event mask that marks which events belong to a newly filled bank, the bank index of that event, and the bank the DMA is currently moving. In two-bank mode a transfer already running on the older bank is allowed to finish. An event that is not tied to a new bank drops the request at once.

A self-clearing toggle-reset strobe forces the next data PID of the endpoint back to DATA0. Each completed packet flips the PID between DATA0 and DATA1.

Top module: `ep_irq_gate`

## Requirements
- R1: After synchronous reset, all enables, the pause control, the interrupt line, the toggle-reset pulse and the next-PID output (0 = DATA0, 1 = DATA1) are zero.
- R2: A one on bit i of `en_set` sets enable bit i, visible on `en_q` one cycle later. `pause_set` works the same way for `pause_q`.
- R3: A zero on any set or clear strobe leaves the matching bit unchanged. Strobes on one bit leave every other bit unchanged.
- R4: A one on bit i of `en_clr` clears enable bit i one cycle later. When the set and clear strobes of the same bit are both one in a cycle, the bit ends up zero.
- R5: `irq` is one exactly when, at the previous clock edge, some event flag and its enable were both one.
- R6: While `pause_q` is zero, `dma_req` equals `dma_req_in` in the same cycle, whatever the flags are.
- R7: While `pause_q` is one and any pending event is not marked as new-bank in `evt_new_bank`, `dma_req` is zero in the same cycle. This holds even when that event's enable is zero.
- R8: While `pause_q` is one and every pending event is new-bank, `dma_req` follows `dma_req_in` only if `dual_bank` is one, `dma_busy` is one and `dma_bank` differs from `evt_bank`. Otherwise `dma_req` is zero, so no request is raised for the new bank.
- R9: The request resumes in the same cycle the pending flags are acknowledged (drop to zero). It also resumes one cycle after a `pause_clr` strobe.
- R10: A `tgl_rst_set` strobe makes `tgl_pulse` one for exactly one cycle and makes `next_pid_data1` zero one cycle later, and this wins over a simultaneous `pkt_done`. Otherwise each `pkt_done` flips `next_pid_data1` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_set | input | NUM_EVT | Write-one-to-set strobes for the interrupt enables |
| en_clr | input | NUM_EVT | Write-one-to-clear strobes for the interrupt enables |
| pause_set | input | 1 | Sets the DMA pause control |
| pause_clr | input | 1 | Clears the DMA pause control |
| tgl_rst_set | input | 1 | Requests a data toggle reset to DATA0 |
| pkt_done | input | 1 | A data packet completed; advance the toggle |
| evt_flags | input | NUM_EVT | Pending endpoint event flags |
| evt_new_bank | input | NUM_EVT | Marks events that belong to a newly filled bank |
| evt_bank | input | 1 | Bank index of the new-bank event |
| dual_bank | input | 1 | Two-bank mode |
| dma_busy | input | 1 | A DMA transfer is running |
| dma_bank | input | 1 | Bank the running DMA transfer is moving |
| dma_req_in | input | 1 | DMA request from the bank logic |
| en_q | output | NUM_EVT | Current interrupt enables |
| pause_q | output | 1 | Current DMA pause control |
| irq | output | 1 | Registered endpoint interrupt |
| dma_req | output | 1 | Gated DMA request |
| tgl_pulse | output | 1 | One-cycle toggle-reset pulse |
| next_pid_data1 | output | 1 | Next data PID: 0 = DATA0, 1 = DATA1 |

## Verification
Register state (enables, pause, toggle) is due one edge after its strobe. The interrupt line needs a second edge when an enable changes, and one edge when only the flags change. The DMA request is combinational, so it is checked one time step after its inputs change, with no clock edge in between. The bench drives each stimulus, waits exactly the number of edges given above, and samples one time unit after the rising edge. For the register-based results it also samples before that edge, to show the value has not arrived early.

// File: rtl/ep_irq_gate_pkg.sv
package ep_irq_gate_pkg;
    parameter int NUM_EVT = 12;

    typedef logic bank_t;

    typedef struct packed {
        logic  dual;
        logic  busy;
        bank_t dma_bank;
        bank_t evt_bank;
        logic  req_in;
    } dma_ctx_t;

    function automatic logic any_set(input logic [NUM_EVT-1:0] v);
        return |v;
    endfunction
endpackage

// File: rtl/ep_w1s_w1c_reg.sv
module ep_w1s_w1c_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= (q_o | set_i) & ~clr_i;
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        |(set_i & ~clr_i) |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
        |clr_i |=> ((q_o & $past(clr_i)) == '0));
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((set_i | clr_i) == '0) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/ep_dma_gate.sv
module ep_dma_gate
    import ep_irq_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pause_i,
    input  logic [NUM_EVT-1:0] flags_i,
    input  logic [NUM_EVT-1:0] new_bank_i,
    input  dma_ctx_t           ctx_i,
    output logic               req_o
);
    logic pend, loose, gate_on, finish_ok;

    always_comb begin
        pend      = any_set(flags_i);
        loose     = any_set(flags_i & ~new_bank_i);
        gate_on   = pause_i && pend;
        finish_ok = ctx_i.dual && ctx_i.busy && (ctx_i.dma_bank != ctx_i.evt_bank) && !loose;
        req_o     = ctx_i.req_in && (!gate_on || finish_ok);
    end

    assert_passthru_R6: assert property (@(posedge clk) disable iff (rst)
        !pause_i |-> (req_o == ctx_i.req_in));
    assert_loose_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (pause_i && |(flags_i & ~new_bank_i)) |-> !req_o);
    assert_single_bank_R8: assert property (@(posedge clk) disable iff (rst)
        (pause_i && |flags_i && !ctx_i.dual) |-> !req_o);
    assert_no_grant_R9: assert property (@(posedge clk) disable iff (rst)
        !ctx_i.req_in |-> !req_o);
endmodule

// File: rtl/ep_toggle.sv
module ep_toggle (
    input  logic clk,
    input  logic rst,
    input  logic reset_req_i,
    input  logic pkt_done_i,
    output logic pulse_o,
    output logic data1_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_o <= 1'b0;
            data1_o <= 1'b0;
        end else begin
            pulse_o <= reset_req_i && !pulse_o;
            if (reset_req_i)     data1_o <= 1'b0;
            else if (pkt_done_i) data1_o <= ~data1_o;
        end
    end

    assert_pulse_self_clear_R10: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);
    assert_pid_data0_R10: assert property (@(posedge clk) disable iff (rst)
        reset_req_i |=> !data1_o);
endmodule

// File: rtl/ep_irq_gate.sv
module ep_irq_gate
    import ep_irq_gate_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] en_set,
    input  logic [NUM_EVT-1:0] en_clr,
    input  logic               pause_set,
    input  logic               pause_clr,
    input  logic               tgl_rst_set,
    input  logic               pkt_done,
    input  logic [NUM_EVT-1:0] evt_flags,
    input  logic [NUM_EVT-1:0] evt_new_bank,
    input  logic               evt_bank,
    input  logic               dual_bank,
    input  logic               dma_busy,
    input  logic               dma_bank,
    input  logic               dma_req_in,
    output logic [NUM_EVT-1:0] en_q,
    output logic               pause_q,
    output logic               irq,
    output logic               dma_req,
    output logic               tgl_pulse,
    output logic               next_pid_data1
);
    dma_ctx_t ctx;

    ep_w1s_w1c_reg #(.WIDTH(NUM_EVT)) u_en (
        .clk(clk), .rst(rst), .set_i(en_set), .clr_i(en_clr), .q_o(en_q)
    );

    ep_w1s_w1c_reg #(.WIDTH(1)) u_pause (
        .clk(clk), .rst(rst), .set_i(pause_set), .clr_i(pause_clr), .q_o(pause_q)
    );

    always_comb begin
        ctx.dual     = dual_bank;
        ctx.busy     = dma_busy;
        ctx.dma_bank = dma_bank;
        ctx.evt_bank = evt_bank;
        ctx.req_in   = dma_req_in;
    end

    ep_dma_gate u_gate (
        .clk(clk), .rst(rst), .pause_i(pause_q), .flags_i(evt_flags),
        .new_bank_i(evt_new_bank), .ctx_i(ctx), .req_o(dma_req)
    );

    ep_toggle u_tgl (
        .clk(clk), .rst(rst), .reset_req_i(tgl_rst_set), .pkt_done_i(pkt_done),
        .pulse_o(tgl_pulse), .data1_o(next_pid_data1)
    );

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= any_set(evt_flags & en_q);
    end

    assert_irq_timing_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_flags & en_q) == '0 |=> !irq);
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (en_q == '0 && !pause_q && !irq && !tgl_pulse && !next_pid_data1));
endmodule

// File: tb/tb_ep_irq_gate.sv
`timescale 1ns/1ps
module tb_ep_irq_gate;
    import ep_irq_gate_pkg::*;

    logic clk = 0;
    logic rst;
    logic [NUM_EVT-1:0] en_set, en_clr, evt_flags, evt_new_bank, en_q;
    logic pause_set, pause_clr, tgl_rst_set, pkt_done;
    logic evt_bank, dual_bank, dma_busy, dma_bank, dma_req_in;
    logic pause_q, irq, dma_req, tgl_pulse, next_pid_data1;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ep_irq_gate dut (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        en_set = '0; en_clr = '0; pause_set = 0; pause_clr = 0;
        tgl_rst_set = 0; pkt_done = 0;
    endtask

    task automatic t_reset();
        rst = 1; idle();
        evt_flags = '0; evt_new_bank = '0; evt_bank = 0; dual_bank = 0;
        dma_busy = 0; dma_bank = 0; dma_req_in = 0;
        step(); step();
        rst = 0;
        step();
        chk("R1 en_q", en_q, 0);
        chk("R1 pause", pause_q, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tgl", {tgl_pulse, next_pid_data1}, 0);
    endtask

    task automatic t_set_clear();
        en_set = 12'h0A5; step(); idle();
        chk("R2 set", en_q, 12'h0A5);
        en_set = '0; en_clr = '0; step();
        chk("R3 zero strobes hold", en_q, 12'h0A5);
        en_set = 12'h100; step(); idle();
        chk("R3 other bits kept", en_q, 12'h1A5);
        en_clr = 12'h005; step(); idle();
        chk("R4 clear", en_q, 12'h1A0);
        en_set = 12'h003; en_clr = 12'h001; step(); idle();
        chk("R4 clear wins", en_q, 12'h1A2);
        pause_set = 1; step(); idle();
        chk("R2 pause set", pause_q, 1);
        pause_set = 1; pause_clr = 1; step(); idle();
        chk("R4 pause clear wins", pause_q, 0);
    endtask

    task automatic t_irq();
        evt_flags = 12'h001; step();
        chk("R5 unenabled flag", irq, 0);
        evt_flags = 12'h002; #1;
        chk("R5 not early", irq, 0);
        step();
        chk("R5 irq due", irq, 1);
        evt_flags = '0; step();
        chk("R5 irq drops", irq, 0);
    endtask

    task automatic t_dma();
        dma_req_in = 1; evt_flags = 12'h001; #1;
        chk("R6 passthrough", dma_req, 1);
        pause_set = 1; step(); idle();
        chk("R7 withheld even with enable zero", dma_req, 0);
        evt_flags = '0; #1;
        chk("R9 resume on ack", dma_req, 1);
        evt_new_bank = 12'h010; evt_flags = 12'h010; evt_bank = 1;
        dual_bank = 1; dma_busy = 1; dma_bank = 0; #1;
        chk("R8 older bank finishes", dma_req, 1);
        evt_flags = 12'h011; #1;
        chk("R7 non-bank drops at once", dma_req, 0);
        evt_flags = 12'h010; dma_busy = 0; #1;
        chk("R8 no request for new bank", dma_req, 0);
        dma_busy = 1; dual_bank = 0; #1;
        chk("R8 single bank withholds", dma_req, 0);
        dual_bank = 1; dma_bank = 1; #1;
        chk("R8 same bank withholds", dma_req, 0);
        pause_clr = 1; #1;
        chk("R9 not before edge", dma_req, 0);
        step(); idle();
        chk("R9 resume after pause clear", dma_req, 1);
        evt_flags = '0; evt_new_bank = '0;
    endtask

    task automatic t_toggle();
        pkt_done = 1; step(); idle();
        chk("R10 toggle flips", next_pid_data1, 1);
        tgl_rst_set = 1; pkt_done = 1; step(); idle();
        chk("R10 reset wins, pulse", {tgl_pulse, next_pid_data1}, 2'b10);
        step();
        chk("R10 pulse self clears", tgl_pulse, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_set_clear();
                t_irq();
                t_dma();
                t_toggle();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule